// File: doc/BRIEF.md
# Multi-mode pixel hit counter

This block is the digital counter that sits behind the discriminator of one pixel in a hybrid pixel detector. An asynchronous hit level from the comparator is brought into the reference clock domain and drives a single saturating counter. What that counter means depends on a per-pixel mode field. It can hold a count of hit events. It can hold a time of arrival, measured as clock ticks from the first hit until the acquisition window ends. It can hold a time over threshold, measured as clock ticks while the hit stays high.

Counting happens only while the shutter input is high. Once the shutter drops, the value is frozen. It can then be taken either from a parallel output or through a serial shift-out port, one bit per shift strobe. A synchronous clear zeroes the counter and disarms the arrival-time logic before the next acquisition.

Top module: `pixel_hit_counter`

## Requirements
- R1: After reset the counter is zero, `rd_valid_o` is 1 (shutter low), `rd_data_o` is 0 and `rd_sout_o` is 0.
- R2: While `shutter_i` is low the counter does not change, whatever `hit_i` does (only `clear_i` alters it).
- R3: Mode 0 (event count): the counter gains exactly one per rising edge of the synchronised hit; a hit set just after a clock edge first affects the count at the third edge.
- R4: Mode 2 (time over threshold): the counter gains one per clock cycle in which the synchronised hit is high, so a hit held for H cycles adds H.
- R5: Mode 1 (time of arrival): the first synchronised rising edge arms the logic, and the counter then gains one per cycle until the shutter closes; later hits change nothing until a clear.
- R6: The counter is CNT_W bits (default 14) and holds at 2^CNT_W-1 instead of wrapping.
- R7: `clear_i` high at a clock edge sets the counter to zero and disarms the arrival-time logic.
- R8: `rd_valid_o` is 1 only while `shutter_i` is low; while the shutter is high `rd_data_o` reads 0, and otherwise it shows the counter.
- R9: `rd_load_i` with the shutter low copies the counter into the shift register; its MSB is on `rd_sout_o` and each `rd_shift_i` edge moves the next lower bit out, MSB first.
- R10: Mode 3 is reserved: no counting takes place in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 event, 1 arrival time, 2 time over threshold, 3 off |
| shutter_i | input | 1 | Acquisition window, synchronous to clk_i |
| hit_i | input | 1 | Asynchronous discriminator level |
| clear_i | input | 1 | Synchronous counter and arm clear |
| rd_load_i | input | 1 | Load shift register from counter (shutter low only) |
| rd_shift_i | input | 1 | Shift serial readout one bit |
| rd_data_o | output | CNT_W | Parallel counter readout |
| rd_valid_o | output | 1 | Readout valid (shutter low) |
| rd_sout_o | output | 1 | Serial readout bit, MSB first |

## Verification
Event mode is swept over pulse counts from one to five and low gaps from one to three cycles. This separates true edge detection from level counting and shows whether single-cycle gaps are lost in the synchroniser. Time over threshold is swept over pulse widths one to six, plus a two-pulse case, to pin down the exact latency and width accounting. Time of arrival is swept over window lengths, with a second hit injected in longer windows to show it is ignored. A hit held for longer than the counter range checks saturation, and serial readout of a known value checks bit order.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic [1:0] {
    MODE_EVT = 2'd0,
    MODE_TOA = 2'd1,
    MODE_TOT = 2'd2,
    MODE_OFF = 2'd3
  } pix_mode_e;
endpackage

// File: rtl/pxc_hit_sync.sv
module pxc_hit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic level_o,
  output logic rise_o
);
  // STAGES flops for metastability, one more to hold the previous level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], hit_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
  import pxc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pix_mode_e mode_i,
  input  logic      shutter_i,
  input  logic      clear_i,
  input  logic      level_i,
  input  logic      rise_i,
  output logic      inc_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            armed_q <= 1'b0;
    else if (clear_i)                                       armed_q <= 1'b0;
    else if (mode_i == MODE_TOA && shutter_i && rise_i)     armed_q <= 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      MODE_EVT: inc_o = shutter_i & rise_i;
      MODE_TOA: inc_o = shutter_i & (armed_q | rise_i);
      MODE_TOT: inc_o = shutter_i & level_i;
      default:  inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pxc_sat_cnt.sv
module pxc_sat_cnt #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pxc_shift_out.sv
module pxc_shift_out #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [CNT_W-1:0] par_i,
  output logic             sout_o
);
  logic [CNT_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= par_i;
    else if (shift_i) sr_q <= {sr_q[CNT_W-2:0], 1'b0};
  end

  assign sout_o = sr_q[CNT_W-1];
endmodule

// File: rtl/pixel_hit_counter.sv
module pixel_hit_counter
  import pxc_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             shutter_i,
  input  logic             hit_i,
  input  logic             clear_i,
  input  logic             rd_load_i,
  input  logic             rd_shift_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             rd_sout_o
);
  logic             level, rise, inc;
  logic [CNT_W-1:0] cnt;
  pix_mode_e        mode;

  assign mode = pix_mode_e'(mode_i);

  pxc_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .hit_i, .level_o(level), .rise_o(rise)
  );

  pxc_ctrl u_ctrl (
    .clk_i, .rst_ni, .mode_i(mode), .shutter_i, .clear_i,
    .level_i(level), .rise_i(rise), .inc_o(inc)
  );

  pxc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clear_i, .inc_i(inc), .cnt_o(cnt)
  );

  pxc_shift_out #(.CNT_W(CNT_W)) u_sout (
    .clk_i, .rst_ni, .load_i(rd_load_i & ~shutter_i), .shift_i(rd_shift_i),
    .par_i(cnt), .sout_o(rd_sout_o)
  );

  assign rd_valid_o = ~shutter_i;
  assign rd_data_o  = shutter_i ? '0 : cnt;
endmodule

// File: rtl/pixel_hit_counter_chk.sv
module pixel_hit_counter_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             shutter_i,
  input logic             clear_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rd_data_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  // R2
  hold_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutter_i && !clear_i) |=> $stable(cnt));
  // R3
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt != CntMax) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CntMax && !clear_i) |=> cnt == CntMax);
  // R7
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt == '0);
  // R8
  open_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutter_i |-> rd_data_o == '0);
  // R10
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !clear_i) |=> $stable(cnt));
endmodule

bind pixel_hit_counter pixel_hit_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .mode_i, .shutter_i, .clear_i, .cnt, .rd_data_o
);

// File: tb/pixel_hit_counter_tb.sv
module pixel_hit_counter_tb;
  localparam int W = 14;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         shutter = 1'b0, hit = 1'b0, clr = 1'b0, ld = 1'b0, sh = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_valid, sout;
  int           n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pixel_hit_counter #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .shutter_i(shutter), .hit_i(hit),
    .clear_i(clr), .rd_load_i(ld), .rd_shift_i(sh),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_sout_o(sout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
  endtask

  task automatic pulse(input int hi, input int lo);
    hit = 1'b1; tick(hi); hit = 1'b0; tick(lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(2); rst_n = 1'b1; tick(1);
    // R1 reset state
    chk("R1 data", int'(rd_data), 0);
    chk("R1 valid", int'(rd_valid), 1);
    chk("R1 sout", int'(sout), 0);

    // R3 event count sweep
    mode = 2'd0;
    for (int n = 1; n <= 5; n++) begin
      for (int g = 1; g <= 3; g++) begin
        do_clear(); shutter = 1'b1; tick(3);
        for (int p = 0; p < n; p++) pulse(2, g);
        tick(4);
        // R8 read blocked while open
        if (n == 1 && g == 1) begin
          chk("R8 valid open", int'(rd_valid), 0);
          chk("R8 data open", int'(rd_data), 0);
        end
        shutter = 1'b0; tick(1);
        chk("R3 events", int'(rd_data), n);
      end
    end

    // R2 hits with shutter closed
    pulse(2, 2); pulse(3, 3); tick(3);
    chk("R2 closed hold", int'(rd_data), 5);

    // R7 clear
    do_clear();
    chk("R7 clear", int'(rd_data), 0);

    // R4 time over threshold sweep
    mode = 2'd2;
    for (int h = 1; h <= 6; h++) begin
      do_clear(); shutter = 1'b1; tick(3);
      pulse(h, 4);
      shutter = 1'b0; tick(1);
      chk("R4 width", int'(rd_data), h);
    end
    do_clear(); shutter = 1'b1; tick(2);
    pulse(3, 2); pulse(5, 4);
    shutter = 1'b0; tick(1);
    chk("R4 two pulses", int'(rd_data), 8);

    // R5 time of arrival sweep, second hit ignored when T>=6
    mode = 2'd1;
    for (int t = 3; t <= 9; t++) begin
      do_clear(); shutter = 1'b1; tick(2);
      hit = 1'b1; tick(1);
      for (int i = 1; i < t; i++) begin
        hit = (t >= 6 && i == 3);
        tick(1);
      end
      hit = 1'b0; shutter = 1'b0; tick(1);
      chk("R5 arrival", int'(rd_data), t - 2);
    end
    // R7 disarm: after clear, open window without hit -> no count
    do_clear(); shutter = 1'b1; tick(6); shutter = 1'b0; tick(1);
    chk("R7 disarmed", int'(rd_data), 0);

    // R10 reserved mode
    mode = 2'd3; do_clear(); shutter = 1'b1; tick(2);
    pulse(3, 2); pulse(2, 2);
    shutter = 1'b0; tick(1);
    chk("R10 off", int'(rd_data), 0);

    // R9 serial readout of a known value (ToT width 13 -> 13)
    mode = 2'd2; do_clear(); shutter = 1'b1; tick(2);
    pulse(13, 4); shutter = 1'b0; tick(1);
    chk("R9 value", int'(rd_data), 13);
    ld = 1'b1; tick(1); ld = 1'b0;
    for (int b = W - 1; b >= 0; b--) begin
      chk("R9 bit", int'(sout), (13 >> b) & 1);
      sh = 1'b1; tick(1); sh = 1'b0;
    end
    // R9 load blocked while shutter open
    shutter = 1'b1; ld = 1'b1; tick(1); ld = 1'b0; shutter = 1'b0; tick(1);
    chk("R9 no load open", int'(sout), 0);

    // R6 saturation
    do_clear(); shutter = 1'b1; tick(2);
    pulse(MAXV + 20, 4); shutter = 1'b0; tick(1);
    chk("R6 saturate", int'(rd_data), MAXV);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule